// File: doc/BRIEF.md
# Packed Lane Shift Unit

This block shifts a 64-bit operand that is viewed as a row of equal lanes: four 16-bit words, two 32-bit dwords or one 64-bit qword. Every lane is shifted by one common count. Three shift kinds are offered: shift left with zero fill, shift right with zero fill, and shift right with sign fill (word and dword lanes only). A 3-bit operation code selects both the kind and the lane size.

The count comes from one of two sources. One is an 8-bit immediate, zero-extended. The other is a full 64-bit count operand, read as one unsigned number and never split into lanes. A count at or above the lane width does not wrap. Instead it empties the lane, or, for the sign-filling kind, floods the lane with its sign bit. The shift datapath is combinational. A parameter places an output register behind it, and that register is present by default.

Top module: `pls_unit`

## Requirements
- R1: `op_i` selects the operation: 0 left/word, 1 left/dword, 2 left/qword, 3 right-zero/word, 4 right-zero/dword, 5 right-zero/qword, 6 right-sign/word, 7 right-sign/dword. Word lanes occupy bits [16k+15:16k], dword lanes bits [32k+31:32k], and the qword lane bits [63:0].
- R2: Every lane is shifted by the same count. A count of zero returns `data_i` unchanged for every operation.
- R3: A left shift moves bits toward the lane's MSB and fills the vacated low bits with zeros. No bit crosses into a neighbouring lane.
- R4: A zero-fill right shift moves bits toward the lane's LSB and fills the vacated high bits with zeros. No bit crosses a lane boundary.
- R5: A sign-fill right shift fills the vacated high bits of each word or dword lane with that lane's own bit 15 or bit 31.
- R6: For the left and zero-fill right shifts, a count equal to or greater than the lane width (16, 32 or 64) makes that lane zero.
- R7: For the sign-fill right shift, a count equal to or greater than the lane width makes each lane all ones if its sign bit was 1, and all zeros otherwise.
- R8: With `imm_sel_i`=1 the count is `imm_i` zero-extended, and `cnt_i` has no effect. With `imm_sel_i`=0 the count is `cnt_i`, and `imm_i` has no effect.
- R9: `cnt_i` is compared as a 64-bit unsigned value. Any set bit at position 6 or above counts as an oversized shift, and the low bits are not used on their own in that case.
- R10: With the output register present (default), `res_o` shows the result for the inputs of the previous rising clock edge. While `rst_n` is low, `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_i | input | 3 | Operation code (kind and lane size) |
| imm_sel_i | input | 1 | 1: count from `imm_i`; 0: count from `cnt_i` |
| imm_i | input | 8 | Immediate shift count |
| cnt_i | input | 64 | Scalar 64-bit shift count |
| data_i | input | 64 | Packed operand to shift |
| res_o | output | 64 | Shifted packed result |

## Verification
Count-source selection and oversize detection act in the same cycle. The hard case is when the unselected source holds a count that would be oversized and the selected one holds a small count, or the reverse. The bench provokes this with an immediate of 2 while `cnt_i` is all ones, and with a count operand of 2 while the immediate is 255. In both cases the result must match a 2-bit shift exactly. A second coincidence is a large `cnt_i` whose low six bits alone would look like a small legal count. For that case the result must be the cleared or sign-flooded lane and not a short shift.

// File: rtl/pls_pkg.sv
package pls_pkg;

   localparam int W_BITS = 16;
   localparam int D_BITS = 32;
   localparam int Q_BITS = 64;
   localparam int N_SIZES = 3;

   typedef enum logic [2:0] {
      OP_SLL_W = 3'd0,
      OP_SLL_D = 3'd1,
      OP_SLL_Q = 3'd2,
      OP_SRL_W = 3'd3,
      OP_SRL_D = 3'd4,
      OP_SRL_Q = 3'd5,
      OP_SRA_W = 3'd6,
      OP_SRA_D = 3'd7
   } pls_op_e;

   typedef enum logic [1:0] {
      K_SLL = 2'd0,
      K_SRL = 2'd1,
      K_SRA = 2'd2
   } pls_kind_e;

   typedef enum logic [1:0] {
      LN_W = 2'd0,
      LN_D = 2'd1,
      LN_Q = 2'd2
   } pls_lane_e;

   typedef struct packed {
      pls_kind_e kind;
      pls_lane_e lane;
   } pls_dec_t;

   function automatic pls_dec_t pls_decode(input logic [2:0] op);
      pls_dec_t d;
      case (op)
         OP_SLL_W: d = '{kind: K_SLL, lane: LN_W};
         OP_SLL_D: d = '{kind: K_SLL, lane: LN_D};
         OP_SLL_Q: d = '{kind: K_SLL, lane: LN_Q};
         OP_SRL_W: d = '{kind: K_SRL, lane: LN_W};
         OP_SRL_D: d = '{kind: K_SRL, lane: LN_D};
         OP_SRL_Q: d = '{kind: K_SRL, lane: LN_Q};
         OP_SRA_W: d = '{kind: K_SRA, lane: LN_W};
         default:  d = '{kind: K_SRA, lane: LN_D};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pls_count.sv
module pls_count
   import pls_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int IMM_W = 8,
   parameter int LIMIT = 64,
   localparam int SH_W  = $clog2(LIMIT),
   localparam int AMT_W = SH_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             imm_sel_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [AMT_W-1:0] amt_o
);

   localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(LIMIT);

   if (IMM_W > CNT_W) begin : g_bad_imm
      $error("pls_count: immediate wider than count operand");
   end
   if ((1 << SH_W) != LIMIT) begin : g_bad_lim
      $error("pls_count: LIMIT must be a power of two");
   end

   logic [CNT_W-1:0] full;
   logic             big;

   always_comb begin
      full  = imm_sel_i ? CNT_W'(imm_i) : cnt_i;
      big   = |full[CNT_W-1:SH_W];
      amt_o = big ? AMT_MAX : {1'b0, full[SH_W-1:0]};
   end

   // R9: the clamped amount never exceeds the widest lane
   p_amt_bound_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      amt_o <= AMT_MAX);

   // R8: a small immediate passes through whatever the wide operand holds
   p_imm_pass_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (imm_sel_i && (CNT_W'(imm_i) < CNT_W'(LIMIT))) |-> (amt_o == AMT_W'(imm_i)));

endmodule

// File: rtl/pls_lane_shift.sv
module pls_lane_shift
   import pls_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int AMT_W  = 7,
   localparam int SH_W  = $clog2(LANE_W)
) (
   input  pls_kind_e         kind_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic [LANE_W-1:0] lane_o
);

   localparam logic [AMT_W-1:0] LIM = AMT_W'(LANE_W);

   if (SH_W >= AMT_W) begin : g_bad_amt
      $error("pls_lane_shift: amount field too narrow for lane");
   end

   logic            over;
   logic [SH_W-1:0] sh;

   always_comb begin
      over = (amt_i >= LIM);
      sh   = amt_i[SH_W-1:0];
      case (kind_i)
         K_SLL:   lane_o = over ? '0 : (lane_i << sh);
         K_SRL:   lane_o = over ? '0 : (lane_i >> sh);
         default: lane_o = over ? {LANE_W{lane_i[LANE_W-1]}}
                                : LANE_W'($signed(lane_i) >>> sh);
      endcase
   end

endmodule

// File: rtl/pls_lane_array.sv
module pls_lane_array
   import pls_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int AMT_W  = 7,
   localparam int N_LANE = DATA_W / LANE_W
) (
   input  pls_kind_e         kind_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);

   if ((DATA_W % LANE_W) != 0) begin : g_bad_split
      $error("pls_lane_array: DATA_W not a multiple of LANE_W");
   end

   for (genvar k = 0; k < N_LANE; k++) begin : g_lane
      pls_lane_shift #(
         .LANE_W (LANE_W),
         .AMT_W  (AMT_W)
      ) i_shift (
         .kind_i (kind_i),
         .amt_i  (amt_i),
         .lane_i (data_i[k*LANE_W +: LANE_W]),
         .lane_o (data_o[k*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/pls_unit.sv
module pls_unit
   import pls_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int CNT_W   = 64,
   parameter int IMM_W   = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int AMT_W  = $clog2(Q_BITS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic              imm_sel_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] res_o
);

   if ((DATA_W % Q_BITS) != 0) begin : g_bad_data
      $error("pls_unit: DATA_W must be a multiple of 64");
   end
   if (CNT_W < AMT_W) begin : g_bad_cnt
      $error("pls_unit: count operand too narrow");
   end

   pls_dec_t          dec;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] by_size [N_SIZES];
   logic [DATA_W-1:0] res_nxt;

   assign dec = pls_decode(op_i);

   pls_count #(
      .CNT_W (CNT_W),
      .IMM_W (IMM_W),
      .LIMIT (Q_BITS)
   ) i_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .imm_sel_i (imm_sel_i),
      .imm_i     (imm_i),
      .cnt_i     (cnt_i),
      .amt_o     (amt)
   );

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      pls_lane_array #(
         .DATA_W (DATA_W),
         .LANE_W (W_BITS << g),
         .AMT_W  (AMT_W)
      ) i_array (
         .kind_i (dec.kind),
         .amt_i  (amt),
         .data_i (data_i),
         .data_o (by_size[g])
      );
   end

   always_comb begin
      case (dec.lane)
         LN_W:    res_nxt = by_size[0];
         LN_D:    res_nxt = by_size[1];
         default: res_nxt = by_size[2];
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) res_o <= '0;
         else        res_o <= res_nxt;
      end

      // R10: registered output trails the combinational result by one edge
      p_latency_r10 : assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (res_o == $past(res_nxt)));
   end else begin : g_comb
      assign res_o = res_nxt;
   end

   // R2: zero count leaves the operand untouched
   p_zero_pass_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (amt == '0) |-> (res_nxt == data_i));

   // R6: an oversized count for a zero-fill kind empties the result
   p_over_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ((dec.kind != K_SRA) && (amt == AMT_W'(Q_BITS))) |-> (res_nxt == '0));

   // R7: oversized sign-fill shift of word lanes floods the lowest word with its sign
   p_sign_flood_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((dec.kind == K_SRA) && (dec.lane == LN_W) && (amt >= AMT_W'(W_BITS)))
      |-> (res_nxt[W_BITS-1:0] == {W_BITS{data_i[W_BITS-1]}}));

   // R5: a sign-fill shift keeps every dword lane's sign bit
   p_sign_keep_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ((dec.kind == K_SRA) && (dec.lane == LN_D))
      |-> ((res_nxt[D_BITS-1] == data_i[D_BITS-1]) &&
           (res_nxt[2*D_BITS-1] == data_i[2*D_BITS-1])));

endmodule

// File: tb/test_pls_unit.sv
`timescale 1ns/1ps
module test_pls_unit;

   localparam realtime TCK = 5.0;

   typedef struct packed {
      logic [2:0]  op;
      logic        sel;
      logic [7:0]  imm;
      logic [63:0] cnt;
      logic [63:0] data;
      logic [15:0] tag;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      // R1 R3: op 0 word left by 4
      '{3'd0, 1'b1, 8'd4,   64'd0, 64'h8001_7fff_1234_ffff, "R3"},
      '{3'd1, 1'b1, 8'd8,   64'd0, 64'h89ab_cdef_0123_4567, "R1"},
      '{3'd2, 1'b0, 8'd0,   64'd12, 64'hf000_0000_0000_0abc, "R3"},
      // R4 zero-fill right
      '{3'd3, 1'b1, 8'd5,   64'd0, 64'h8001_7fff_1234_ffff, "R4"},
      '{3'd4, 1'b0, 8'd0,   64'd31, 64'h8000_0001_ffff_ffff, "R4"},
      '{3'd5, 1'b1, 8'd63,  64'd0, 64'h8000_0000_0000_0000, "R4"},
      // R5 sign-fill right
      '{3'd6, 1'b1, 8'd3,   64'd0, 64'h8000_7ff0_f00f_0ff0, "R5"},
      '{3'd7, 1'b0, 8'd0,   64'd17, 64'h8123_4567_7654_3210, "R5"},
      // R6 oversized zero-fill
      '{3'd0, 1'b1, 8'd16,  64'd0, 64'hffff_ffff_ffff_ffff, "R6"},
      '{3'd4, 1'b1, 8'd32,  64'd0, 64'hdead_beef_cafe_f00d, "R6"},
      '{3'd2, 1'b1, 8'd200, 64'd0, 64'h0123_4567_89ab_cdef, "R6"},
      // R7 oversized sign-fill
      '{3'd6, 1'b1, 8'd16,  64'd0, 64'h8000_7fff_ffff_0001, "R7"},
      '{3'd7, 1'b0, 8'd0,   64'd1000, 64'h7fff_ffff_8000_0000, "R7"},
      // R9 wide count with high bits set
      '{3'd5, 1'b0, 8'd0,   64'h0000_0100_0000_0003, 64'hffff_ffff_ffff_ffff, "R9"},
      '{3'd0, 1'b0, 8'd0,   64'h8000_0000_0000_0000, 64'h1234_5678_9abc_def0, "R9"},
      // R8 unselected source ignored
      '{3'd3, 1'b1, 8'd2,   64'hffff_ffff_ffff_ffff, 64'hf0f0_0f0f_8888_1111, "R8"},
      '{3'd6, 1'b0, 8'd255, 64'd2, 64'hf0f0_0f0f_8888_1111, "R8"},
      // R2 zero count
      '{3'd2, 1'b1, 8'd0,   64'hffff, 64'h0bad_cafe_1357_9bdf, "R2"},
      '{3'd7, 1'b0, 8'd77,  64'd0, 64'h8bad_cafe_9357_9bdf, "R2"}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic        imm_sel_i = 1'b0;
   logic [7:0]  imm_i = '0;
   logic [63:0] cnt_i = '0;
   logic [63:0] data_i = '0;
   logic [63:0] res_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(TCK/2) clk = ~clk;

   pls_unit i_pls_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op_i),
      .imm_sel_i (imm_sel_i),
      .imm_i     (imm_i),
      .cnt_i     (cnt_i),
      .data_i    (data_i),
      .res_o     (res_o)
   );

   function automatic logic [63:0] model(input logic [2:0] op, input logic sel,
                                         input logic [7:0] imm, input logic [63:0] cnt,
                                         input logic [63:0] d);
      logic [63:0] c;
      logic [63:0] r;
      int L;
      int kind;
      int sh;
      c = sel ? {56'd0, imm} : cnt;
      r = '0;
      if (op < 3)      begin kind = 0; L = 16 << op; end
      else if (op < 6) begin kind = 1; L = 16 << (op - 3); end
      else             begin kind = 2; L = 16 << (op - 6); end
      sh = (c < 64'(L)) ? int'(c) : L;
      for (int b = 0; b < 64; b += L) begin
         for (int i = 0; i < L; i++) begin
            if (kind == 0)
               r[b+i] = (i >= sh) ? d[b+i-sh] : 1'b0;
            else if (kind == 1)
               r[b+i] = (i + sh < L) ? d[b+i+sh] : 1'b0;
            else
               r[b+i] = (i + sh < L) ? d[b+i+sh] : d[b+L-1];
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] exp);
      n_vec++;
      if (res_o !== exp) begin
         n_bad++;
         $display("FAIL %s: res_o=%h expected=%h", req, res_o, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      op_i = v.op; imm_sel_i = v.sel; imm_i = v.imm; cnt_i = v.cnt; data_i = v.data;
      @(negedge clk);
      check(string'(v.tag), model(v.op, v.sel, v.imm, v.cnt, v.data));
   endtask

   initial begin
      // reset state, inputs active: R10
      data_i = 64'hffff_ffff_ffff_ffff; imm_sel_i = 1'b1; imm_i = 8'd1;
      repeat (3) @(negedge clk);
      check("R10", 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) apply(VECS[k]);

      // R10: new inputs do not reach res_o before the next rising edge
      apply('{3'd0, 1'b1, 8'd1, 64'd0, 64'h0000_0000_0000_0001, "R10"});
      @(negedge clk);
      op_i = 3'd2; imm_sel_i = 1'b1; imm_i = 8'd8; data_i = 64'h0000_0000_0000_00ff;
      #1;
      check("R10", 64'h0000_0000_0000_0002);
      @(negedge clk);
      check("R10", 64'h0000_0000_0000_ff00);

      // R9: bit 6 alone is oversized; bits 5:0 alone are not
      apply('{3'd5, 1'b0, 8'd0, 64'd64, 64'hffff_ffff_ffff_ffff, "R9"});
      apply('{3'd3, 1'b0, 8'd0, 64'd15, 64'h8000_8000_8000_8000, "R4"});

      // R10: mid-run reset clears the output
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule